// File: doc/BRIEF.md
# Pipeline Arithmetic Overflow Exception Controller

This block is the exception control slice of a five-stage (fetch, decode, execute, memory, write-back) pipeline with a 16-bit datapath. It watches the arithmetic operation in the execute stage. When the result of an add or subtract does not fit in the word, it takes a precise exception. The offending instruction and the two younger instructions behind it become bubbles. The instruction already past the memory stage is left to retire. The fetch address jumps to a fixed handler.

The controller keeps two saved addresses. The first is the address of the faulting instruction. The second is the address the handler may return to. A fixed number of cycles after the redirect, it issues one write of the faulting address into the reserved register R15, so that software can see it. A move-from-coprocessor read port returns either saved address. A jump-register instruction in decode, whose target the datapath reads from the reserved register, redirects fetch back to the program.

Top module: `ovf_exc_ctrl`

## Requirements
- R1: Overflow detection applies only when `ex_valid` is 1 and `ex_kind` is 1 (add) or 2 (subtract). An add overflows when the unsigned sum carries out of bit 15. A subtract overflows when `ex_a` < `ex_b` (unsigned borrow). Kinds 0 and 3 never overflow.
- R2: In the cycle an overflow is taken, `flush_ifid`, `flush_idex` and `flush_exmem` are all 1. `flush_idex` and `flush_exmem` are 0 in every other cycle.
- R3: In the cycle an overflow is taken, `pc_load` is 1 and `pc_target` is the handler address 16'h0F00.
- R4: From the cycle after an overflow is taken, `epc` holds that instruction's `ex_pc` and `epc_resume` holds `ex_pc`+1 (mod 2^16). Neither value changes at any other time.
- R5: Two cycles after an overflow is taken, `rf_wr_en` is 1 for exactly one cycle, with `rf_wr_addr` = 15 and `rf_wr_data` = the saved faulting address.
- R6: An overflow that arrives in either of the two cycles after one was taken is ignored. It causes no flush, no redirect, no change to `epc` or `epc_resume`, and no extra register write.
- R7: `mfc_data` returns `epc` when `mfc_sel` is 0 and `epc_resume` when `mfc_sel` is 1, in the same cycle.
- R8: With `id_jr` at 1 and no overflow taken, `pc_load` is 1, `pc_target` equals `jr_addr`, and only `flush_ifid` is raised. If an overflow is taken in the same cycle, the handler redirect wins.
- R9: While reset is asserted and right after it, every output is 0, except `rf_wr_addr`, which is 15.
- R10: Executing an add of 32 and 65527 (sum 65559) raises the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_kind | input | 2 | Arithmetic kind: 0 none, 1 add, 2 subtract, 3 other |
| ex_a | input | 16 | First ALU operand |
| ex_b | input | 16 | Second ALU operand |
| ex_pc | input | 16 | Word address of the execute-stage instruction |
| id_jr | input | 1 | Decode stage holds a jump-register |
| jr_addr | input | 16 | Jump-register target read from the reserved register |
| mfc_sel | input | 1 | Move-from-coprocessor select: 0 faulting, 1 resume |
| ovf_taken | output | 1 | An exception is taken this cycle |
| busy | output | 1 | Exception in progress; new overflows are ignored |
| flush_ifid | output | 1 | Turn the IF/ID latch into a bubble |
| flush_idex | output | 1 | Turn the ID/EX latch into a bubble |
| flush_exmem | output | 1 | Squash the faulting instruction entering EX/MEM |
| pc_load | output | 1 | Load `pc_target` into the PC |
| pc_target | output | 16 | Redirect address |
| rf_wr_en | output | 1 | Register-file write of the saved address |
| rf_wr_addr | output | 4 | Register index of that write (15) |
| rf_wr_data | output | 16 | Data of that write |
| epc | output | 16 | Saved faulting address |
| epc_resume | output | 16 | Saved resume address |
| mfc_data | output | 16 | Move-from-coprocessor read data |

## Verification
The bench goes after the carry boundary, including the 32 + 65527 add and an add that sums to exactly 0xFFFF. A detector that tested the wrong bit, or treated the operands as signed, would miss the first case or fire on the second. It sends further overflows into the two cycles after a taken one. A design without the lockout would overwrite the saved address and issue a second R15 write. It also pairs a jump-register in decode with an overflow in execute, where wrong priority sends fetch to the program instead of the handler. Random traffic checks the timing of the R15 write and the selection on the read port on every cycle.

// File: rtl/ovf_exc_pkg.sv
package ovf_exc_pkg;
   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_ADD   = 2'd1,
      KIND_SUB   = 2'd2,
      KIND_OTHER = 2'd3
   } alu_kind_e;

   function automatic logic kind_checked(input alu_kind_e k);
      return (k == KIND_ADD) || (k == KIND_SUB);
   endfunction
endpackage

// File: rtl/ovf_detect.sv
module ovf_detect
   import ovf_exc_pkg::*;
#(
   parameter int XLEN        = 16,
   parameter bit SIGNED_MODE = 1'b0
) (
   input  logic            valid,
   input  logic [1:0]      kind,
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   output logic            ovf
);
   localparam int SW = XLEN + 1;

   alu_kind_e       k;
   logic [SW-1:0]   sum_w;
   logic [SW-1:0]   dif_w;
   logic            add_ovf;
   logic            sub_ovf;

   assign k     = alu_kind_e'(kind);
   assign sum_w = {1'b0, op_a} + {1'b0, op_b};
   assign dif_w = {1'b0, op_a} - {1'b0, op_b};

   generate
      if (SIGNED_MODE) begin : g_signed
         assign add_ovf = (op_a[XLEN-1] == op_b[XLEN-1]) &&
                          (sum_w[XLEN-1] != op_a[XLEN-1]);
         assign sub_ovf = (op_a[XLEN-1] != op_b[XLEN-1]) &&
                          (dif_w[XLEN-1] != op_a[XLEN-1]);
      end else begin : g_unsigned
         assign add_ovf = sum_w[XLEN];
         assign sub_ovf = dif_w[XLEN];
      end
   endgenerate

   always_comb begin
      ovf = 1'b0;
      if (valid && kind_checked(k)) begin
         ovf = (k == KIND_ADD) ? add_ovf : sub_ovf;
      end
   end
endmodule

// File: rtl/epc_bank.sv
module epc_bank #(
   parameter int XLEN    = 16,
   parameter int PC_STEP = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [XLEN-1:0] fault_pc,
   input  logic            rd_sel,
   output logic [XLEN-1:0] epc_fault,
   output logic [XLEN-1:0] epc_ret,
   output logic [XLEN-1:0] rd_data
);
   localparam logic [XLEN-1:0] STEP_W = XLEN'(PC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_fault <= '0;
         epc_ret   <= '0;
      end else if (capture) begin
         epc_fault <= fault_pc;
         epc_ret   <= fault_pc + STEP_W;
      end
   end

   assign rd_data = rd_sel ? epc_ret : epc_fault;

   // R4
   ret_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (epc_ret - epc_fault) == STEP_W);
endmodule

// File: rtl/redirect_ctl.sv
module redirect_ctl #(
   parameter int             XLEN    = 16,
   parameter logic [XLEN-1:0] HANDLER = 16'h0F00,
   parameter int             WB_LAT  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ovf_raw,
   input  logic            id_jr,
   input  logic [XLEN-1:0] jr_addr,
   output logic            take,
   output logic            busy,
   output logic            flush_ifid,
   output logic            flush_idex,
   output logic            flush_exmem,
   output logic            pc_load,
   output logic [XLEN-1:0] pc_target,
   output logic            wr_pulse
);
   logic [WB_LAT-1:0] sched;
   logic              jr_take;

   assign busy    = |sched;
   assign take    = ovf_raw && !busy;
   assign jr_take = id_jr && !take;

   generate
      if (WB_LAT == 1) begin : g_short
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sched <= '0;
            else        sched <= take;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sched <= '0;
            else        sched <= {sched[WB_LAT-2:0], take};
         end
      end
   endgenerate

   assign wr_pulse    = sched[WB_LAT-1];
   assign flush_ifid  = take || jr_take;
   assign flush_idex  = take;
   assign flush_exmem = take;
   assign pc_load     = take || jr_take;
   assign pc_target   = take ? HANDLER : jr_addr;

   // R6
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);
   // R5
   single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/ovf_exc_ctrl.sv
module ovf_exc_ctrl #(
   parameter int XLEN        = 16,
   parameter int NREG        = 16,
   parameter int RSV_REG     = 15,
   parameter int PC_STEP     = 1,
   parameter int WB_LAT      = 2,
   parameter bit SIGNED_MODE = 1'b0,
   parameter logic [XLEN-1:0] HANDLER = 16'h0F00,
   localparam int AW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_valid,
   input  logic [1:0]      ex_kind,
   input  logic [XLEN-1:0] ex_a,
   input  logic [XLEN-1:0] ex_b,
   input  logic [XLEN-1:0] ex_pc,
   input  logic            id_jr,
   input  logic [XLEN-1:0] jr_addr,
   input  logic            mfc_sel,
   output logic            ovf_taken,
   output logic            busy,
   output logic            flush_ifid,
   output logic            flush_idex,
   output logic            flush_exmem,
   output logic            pc_load,
   output logic [XLEN-1:0] pc_target,
   output logic            rf_wr_en,
   output logic [AW-1:0]   rf_wr_addr,
   output logic [XLEN-1:0] rf_wr_data,
   output logic [XLEN-1:0] epc,
   output logic [XLEN-1:0] epc_resume,
   output logic [XLEN-1:0] mfc_data
);
   generate
      if (XLEN < 4)            begin : g_bad_xlen  $error("XLEN too small");            end
      if (NREG != (1 << AW))   begin : g_bad_nreg  $error("NREG must be a power of 2"); end
      if (RSV_REG >= NREG)     begin : g_bad_rsv   $error("RSV_REG out of range");     end
      if (WB_LAT < 1)          begin : g_bad_lat   $error("WB_LAT must be >= 1");      end
      if (PC_STEP < 1)         begin : g_bad_step  $error("PC_STEP must be >= 1");     end
   endgenerate

   logic ovf_raw;

   ovf_detect #(.XLEN(XLEN), .SIGNED_MODE(SIGNED_MODE)) u_det (
      .valid (ex_valid),
      .kind  (ex_kind),
      .op_a  (ex_a),
      .op_b  (ex_b),
      .ovf   (ovf_raw)
   );

   redirect_ctl #(.XLEN(XLEN), .HANDLER(HANDLER), .WB_LAT(WB_LAT)) u_redir (
      .clk         (clk),
      .rst_n       (rst_n),
      .ovf_raw     (ovf_raw),
      .id_jr       (id_jr),
      .jr_addr     (jr_addr),
      .take        (ovf_taken),
      .busy        (busy),
      .flush_ifid  (flush_ifid),
      .flush_idex  (flush_idex),
      .flush_exmem (flush_exmem),
      .pc_load     (pc_load),
      .pc_target   (pc_target),
      .wr_pulse    (rf_wr_en)
   );

   epc_bank #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_epc (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (ovf_taken),
      .fault_pc  (ex_pc),
      .rd_sel    (mfc_sel),
      .epc_fault (epc),
      .epc_ret   (epc_resume),
      .rd_data   (mfc_data)
   );

   assign rf_wr_addr = AW'(RSV_REG);
   assign rf_wr_data = epc;

   // R1
   idle_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |-> !ovf_taken);
   // R4
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_taken |=> epc == $past(ex_pc));
   // R6
   hold_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(epc) && $stable(epc_resume));
   // R3
   handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !id_jr) |-> pc_target == HANDLER);
   // R2
   flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_exmem |-> flush_ifid && pc_load);
endmodule

// File: tb/test_ovf_exc_ctrl.sv
module test_ovf_exc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ex_valid = 1'b0;
   logic [1:0]  ex_kind = 2'd0;
   logic [15:0] ex_a = '0, ex_b = '0, ex_pc = '0, jr_addr = '0;
   logic        id_jr = 1'b0, mfc_sel = 1'b0;
   logic        ovf_taken, busy, flush_ifid, flush_idex, flush_exmem, pc_load, rf_wr_en;
   logic [15:0] pc_target, rf_wr_data, epc, epc_resume, mfc_data;
   logic [3:0]  rf_wr_addr;

   int n_chk = 0, n_bad = 0;
   logic [15:0] m_epc = '0, m_res = '0;
   int m_age = 0;

   always #2 clk = ~clk;

   ovf_exc_ctrl i_ovf_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_kind(ex_kind),
      .ex_a(ex_a), .ex_b(ex_b), .ex_pc(ex_pc), .id_jr(id_jr), .jr_addr(jr_addr),
      .mfc_sel(mfc_sel), .ovf_taken(ovf_taken), .busy(busy),
      .flush_ifid(flush_ifid), .flush_idex(flush_idex), .flush_exmem(flush_exmem),
      .pc_load(pc_load), .pc_target(pc_target), .rf_wr_en(rf_wr_en),
      .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data), .epc(epc),
      .epc_resume(epc_resume), .mfc_data(mfc_data)
   );

   function automatic logic exp_ovf(logic v, logic [1:0] k, logic [15:0] a, logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      if (!v) return 1'b0;
      if (k == 2'd1) return s[16];
      if (k == 2'd2) return a < b;
      return 1'b0;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drv(logic v, logic [1:0] k, logic [15:0] a, logic [15:0] b,
                      logic [15:0] pc, logic jr, logic [15:0] ja, logic sel);
      ex_valid = v; ex_kind = k; ex_a = a; ex_b = b; ex_pc = pc;
      id_jr = jr; jr_addr = ja; mfc_sel = sel;
   endtask

   // called at negedge after drv: checks this cycle, then advances the model over the next edge
   task automatic cyc();
      logic raw, tk, jr;
      #1;
      raw = exp_ovf(ex_valid, ex_kind, ex_a, ex_b);
      tk  = raw && (m_age == 0);
      jr  = id_jr && !tk;
      check(raw && !tk ? "R6 ignored ovf" : "R1 ovf_taken", {31'd0, ovf_taken}, {31'd0, tk});
      check("R2 flush_idex", {31'd0, flush_idex}, {31'd0, tk});
      check("R2 flush_exmem", {31'd0, flush_exmem}, {31'd0, tk});
      check("R8 flush_ifid", {31'd0, flush_ifid}, {31'd0, tk | jr});
      check("R3 pc_load", {31'd0, pc_load}, {31'd0, tk | jr});
      if (tk) check("R3 handler target", {16'd0, pc_target}, 32'h0F00);
      else if (jr) check("R8 jr target", {16'd0, pc_target}, {16'd0, jr_addr});
      check("R4 epc", {16'd0, epc}, {16'd0, m_epc});
      check("R4 epc_resume", {16'd0, epc_resume}, {16'd0, m_res});
      check("R5 rf_wr_en", {31'd0, rf_wr_en}, {31'd0, m_age == 2});
      if (m_age == 2) begin
         check("R5 rf_wr_data", {16'd0, rf_wr_data}, {16'd0, m_epc});
         check("R5 rf_wr_addr", {28'd0, rf_wr_addr}, 32'd15);
      end
      check("R7 mfc_data", {16'd0, mfc_data}, {16'd0, mfc_sel ? m_res : m_epc});
      if (tk) begin
         m_epc = ex_pc; m_res = ex_pc + 16'd1; m_age = 1;
      end else if (m_age == 1) m_age = 2;
      else m_age = 0;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20021));
      @(negedge clk);
      #1;
      // R9 reset state
      check("R9 ovf_taken", {31'd0, ovf_taken}, 0);
      check("R9 pc_load", {31'd0, pc_load}, 0);
      check("R9 rf_wr_en", {31'd0, rf_wr_en}, 0);
      check("R9 epc", {16'd0, epc}, 0);
      check("R9 epc_resume", {16'd0, epc_resume}, 0);
      check("R9 busy", {31'd0, busy}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: 32 + 65527 overflows
      drv(1, 2'd1, 16'd32, 16'd65527, 16'd103, 0, 0, 0);
      cyc();
      check("R10 epc 103", {16'd0, epc}, 32'd103);
      // R6: two more overflows during lockout
      drv(1, 2'd1, 16'hFFFF, 16'h0001, 16'h0050, 0, 0, 1);
      cyc();
      drv(1, 2'd2, 16'd1, 16'd9, 16'h0051, 0, 0, 1);
      cyc();
      check("R6 epc kept", {16'd0, epc}, 32'd103);
      // R1: exact 0xFFFF sum, no overflow; kind 3 never
      drv(1, 2'd1, 16'hFFF0, 16'h000F, 16'h0060, 0, 0, 0);
      cyc();
      drv(1, 2'd3, 16'hFFFF, 16'hFFFF, 16'h0061, 0, 0, 0);
      cyc();
      // R8: JR alone
      drv(0, 2'd1, 16'hFFFF, 16'hFFFF, 16'h0062, 1, 16'h0123, 0);
      cyc();
      // R8: JR with overflow -> handler wins
      drv(1, 2'd2, 16'd5, 16'd7, 16'h0200, 1, 16'h0456, 1);
      cyc();
      drv(0, 2'd0, 0, 0, 0, 0, 0, 1);
      cyc();
      cyc();
      cyc();
      check("R7 resume readback", {16'd0, mfc_data}, 32'h0201);
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a, b;
         a = (($urandom % 4) == 0) ? 16'hFFF0 | 16'($urandom % 16) : 16'($urandom);
         b = 16'($urandom);
         drv(($urandom % 10) < 7, 2'($urandom), a, b, 16'($urandom),
             ($urandom % 8) == 0, 16'($urandom), 1'($urandom));
         cyc();
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule